// File: doc/BRIEF.md
# Word Serializer with Line and Diagnostic Loopback

This block turns 16-bit parallel words into a serial bit stream for a transmit line. A loadable shift register takes one word on every sixteenth enabled bit slot and moves it out one bit per enabled slot, most significant bit first. A companion count produces a word-rate clock, which is the serial clock divided by sixteen. Upstream logic uses it to present the next word in step with the serializer.

Two loopback paths sit at the serial edge. When line loopback is on, the transmit data and clock outputs carry an externally supplied serial data and clock pair in place of the serializer. When diagnostic loopback is on, the serializer's own data and clock are also driven onto a separate loopback output pair toward a receiver. When it is off, that pair is held low. The two enables act independently of each other.

The serial bit rate is set by a one-cycle enable (`bit_tick`) on the core clock. The serializer clock output is a one-cycle pulse that marks each new bit.

Top module: `serializer_loopback_tx`

## Requirements
- R1: While reset is asserted and right after it, the serializer data is 0, the serializer clock pulse is 0, the word clock `word_clk` is 1, and with diagnostic loopback off both loopback outputs are 0.
- R2: After reset is released, the first word is loaded on the 16th enabled bit slot. The serializer data stays 0 until that slot.
- R3: Each loaded word leaves most significant bit first. The bit at index 15 appears in the cycle after the load edge, and indices 14 down to 0 follow on the next 15 enabled slots.
- R4: A cycle with `bit_tick` low does not shift the register, does not advance the slot count, and produces no clock pulse. The data and `word_clk` outputs hold their values.
- R5: The serializer clock output is 1 for exactly the cycle after each enabled bit slot, and 0 otherwise.
- R6: `word_clk` is 1 while bits 15..8 of a word are on the line and 0 while bits 7..0 are. It rises in the same cycle that bit 15 appears.
- R7: With `line_lb_en` = 0, `tx_data` and `tx_clk` carry the serializer data and clock pulse.
- R8: With `line_lb_en` = 1, `tx_data` and `tx_clk` follow `lb_data_in` and `lb_clk_in` in the same cycle, with no register on the path.
- R9: With `diag_lb_en` = 1, `diag_data` and `diag_clk` carry the serializer data and clock pulse, whatever the value of `line_lb_en`.
- R10: With `diag_lb_en` = 0, `diag_data` and `diag_clk` are 0.
- R11: `word_in` is sampled only on the load slot. Changes at any other time do not affect the bits being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle enable that marks one serial bit slot |
| word_in | input | 16 | Parallel word to serialize |
| lb_data_in | input | 1 | External serial data for line loopback |
| lb_clk_in | input | 1 | External serial clock for line loopback |
| line_lb_en | input | 1 | Selects the external pair onto the transmit outputs |
| diag_lb_en | input | 1 | Drives the serializer stream onto the loopback outputs |
| tx_data | output | 1 | Transmit serial data |
| tx_clk | output | 1 | Transmit serial clock |
| diag_data | output | 1 | Diagnostic loopback serial data |
| diag_clk | output | 1 | Diagnostic loopback serial clock |
| word_clk | output | 1 | Word-rate clock, serial clock divided by sixteen |

## Verification
The hardest case to bring about from the ports is a word whose bit slots are interrupted by idle cycles. In that case the word boundary, the `word_clk` phase and the held data must all stay put. This has to happen while the loopback selections are being changed, and while `word_in` keeps moving away from the value that was loaded.

The stimulus first primes fifteen slots after reset, so every later word starts on a known load slot. It then sends each word as sixteen enabled slots with an idle cycle inserted after every odd slot. On each cycle the bench drives a changing external loopback pattern and the complement of the word on `word_in`. Every cycle is checked against a bit index and slot number kept in the bench.

// File: rtl/ser_pkg.sv
package ser_pkg;

    // Lane order inside the serial pair bundles
    localparam int LANE_DATA = 0;
    localparam int LANE_CLK  = 1;
    localparam int NUM_LANES = 2;

    typedef enum logic {
        SRC_SER  = 1'b0,
        SRC_LINE = 1'b1
    } tx_src_e;

    function automatic tx_src_e pick_src(input logic line_sel);
        return line_sel ? SRC_LINE : SRC_SER;
    endfunction

endpackage

// File: rtl/ser_bit_counter.sv
module ser_bit_counter #(
    parameter int WORD_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    output logic load,
    output logic word_clk,
    output logic bit_pulse
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(WORD_W / 2);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = bit_tick;
        if (bit_tick) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load      = bit_tick && (st_q.cnt == LAST);
    assign word_clk  = (st_q.cnt < HALF);
    assign bit_pulse = st_q.pulse;

    AST_IDLE_WORDCLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(word_clk)); // R4

    AST_WORDCLK_RISE_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word_clk) |-> $past(load)); // R6

endmodule

// File: rtl/ser_shift_reg.sv
module ser_shift_reg #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    output logic              ser_bit
);
    typedef struct packed {
        logic [WORD_W-1:0] shreg;
    } sh_state_t;

    sh_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.shreg = word_in;
        end else if (bit_tick) begin
            st_d.shreg = {st_q.shreg[WORD_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_bit = st_q.shreg[WORD_W-1];

    AST_LOAD_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ser_bit == $past(word_in[WORD_W-1]))); // R3

    AST_IDLE_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(ser_bit)); // R4

endmodule

// File: rtl/ser_out_sel.sv
module ser_out_sel
    import ser_pkg::*;
(
    input  logic                 line_sel,
    input  logic                 diag_en,
    input  logic [NUM_LANES-1:0] ser_lane,
    input  logic [NUM_LANES-1:0] lb_lane,
    output logic [NUM_LANES-1:0] tx_lane,
    output logic [NUM_LANES-1:0] diag_lane
);
    tx_src_e src;

    assign src = pick_src(line_sel);

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        assign tx_lane[i]   = (src == SRC_LINE) ? lb_lane[i] : ser_lane[i];
        assign diag_lane[i] = diag_en & ser_lane[i];
    end

endmodule

// File: rtl/serializer_loopback_tx.sv
module serializer_loopback_tx
    import ser_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic [WORD_W-1:0] word_in,
    input  logic              lb_data_in,
    input  logic              lb_clk_in,
    input  logic              line_lb_en,
    input  logic              diag_lb_en,
    output logic              tx_data,
    output logic              tx_clk,
    output logic              diag_data,
    output logic              diag_clk,
    output logic              word_clk
);
    logic                 load;
    logic                 bit_pulse;
    logic                 ser_bit;
    logic [NUM_LANES-1:0] ser_lane;
    logic [NUM_LANES-1:0] lb_lane;
    logic [NUM_LANES-1:0] tx_lane;
    logic [NUM_LANES-1:0] diag_lane;

    ser_bit_counter #(.WORD_W(WORD_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .load     (load),
        .word_clk (word_clk),
        .bit_pulse(bit_pulse)
    );

    ser_shift_reg #(.WORD_W(WORD_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_tick(bit_tick),
        .load    (load),
        .word_in (word_in),
        .ser_bit (ser_bit)
    );

    assign ser_lane[LANE_DATA] = ser_bit;
    assign ser_lane[LANE_CLK]  = bit_pulse;
    assign lb_lane[LANE_DATA]  = lb_data_in;
    assign lb_lane[LANE_CLK]   = lb_clk_in;

    ser_out_sel u_sel (
        .line_sel (line_lb_en),
        .diag_en  (diag_lb_en),
        .ser_lane (ser_lane),
        .lb_lane  (lb_lane),
        .tx_lane  (tx_lane),
        .diag_lane(diag_lane)
    );

    assign tx_data   = tx_lane[LANE_DATA];
    assign tx_clk    = tx_lane[LANE_CLK];
    assign diag_data = diag_lane[LANE_DATA];
    assign diag_clk  = diag_lane[LANE_CLK];

    AST_TX_CLK_FROM_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_lb_en && tx_clk) |-> $past(bit_tick)); // R7

    AST_DIAG_CLK_FROM_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        diag_clk |-> $past(bit_tick)); // R9

endmodule

// File: tb/serializer_loopback_tx_bench.sv
module serializer_loopback_tx_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0;
    logic [15:0] word_in = '0;
    logic        lb_data_in = 1'b0;
    logic        lb_clk_in = 1'b0;
    logic        line_lb_en = 1'b0;
    logic        diag_lb_en = 1'b0;
    logic        tx_data, tx_clk, diag_data, diag_clk, word_clk;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    serializer_loopback_tx u_serializer_loopback_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .word_in   (word_in),
        .lb_data_in(lb_data_in),
        .lb_clk_in (lb_clk_in),
        .line_lb_en(line_lb_en),
        .diag_lb_en(diag_lb_en),
        .tx_data   (tx_data),
        .tx_clk    (tx_clk),
        .diag_data (diag_data),
        .diag_clk  (diag_clk),
        .word_clk  (word_clk)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input logic en);
        bit_tick = en;
        @(posedge clk);
        #1;
    endtask

    // R1: reset values
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(tx_data, 1'b0, "R1 tx_data in reset");
        chk(tx_clk, 1'b0, "R1 tx_clk in reset");
        chk(word_clk, 1'b1, "R1 word_clk in reset");
        chk(diag_data, 1'b0, "R1 diag_data in reset");
        chk(diag_clk, 1'b0, "R1 diag_clk in reset");
        rst_n = 1'b1;
        tick(1'b0);
        chk(tx_data, 1'b0, "R1 tx_data after reset");
        chk(word_clk, 1'b1, "R1 word_clk after reset");
    endtask

    // R2: no load during the first fifteen slots
    task automatic t_prime();
        word_in = 16'hFFFF;
        for (int i = 1; i <= 15; i++) begin
            tick(1'b1);
            chk(tx_data, 1'b0, "R2 data before first load");
            chk(word_clk, (i < 8) ? 1'b1 : 1'b0, "R2/R6 word_clk while priming");
            chk(tx_clk, 1'b1, "R5 pulse while priming");
        end
    endtask

    // One word: load slot first, then fifteen shift slots
    task automatic run_word(input logic [15:0] w, input logic line, input logic diag,
                            input logic gaps);
        logic exp_bit;
        line_lb_en = line;
        diag_lb_en = diag;
        for (int k = 0; k < 16; k++) begin
            word_in    = (k == 0) ? w : ~w;
            lb_data_in = ~w[k];
            lb_clk_in  = k[1];
            tick(1'b1);
            exp_bit = w[15-k];
            chk(tx_data, line ? lb_data_in : exp_bit, line ? "R8 tx_data" : "R3/R7/R11 tx_data");
            chk(tx_clk, line ? lb_clk_in : 1'b1, line ? "R8 tx_clk" : "R5/R7 tx_clk");
            chk(word_clk, (k < 8) ? 1'b1 : 1'b0, "R6 word_clk");
            chk(diag_data, diag ? exp_bit : 1'b0, diag ? "R9 diag_data" : "R10 diag_data");
            chk(diag_clk, diag ? 1'b1 : 1'b0, diag ? "R9 diag_clk" : "R10 diag_clk");
            if (gaps && k[0]) begin
                lb_data_in = w[k];
                lb_clk_in  = ~k[1];
                tick(1'b0);
                chk(tx_data, line ? lb_data_in : exp_bit, "R4 data held on idle");
                chk(tx_clk, line ? lb_clk_in : 1'b0, "R4 no pulse on idle");
                chk(word_clk, (k < 8) ? 1'b1 : 1'b0, "R4 word_clk held on idle");
                chk(diag_data, diag ? exp_bit : 1'b0, "R4 diag data held");
                chk(diag_clk, 1'b0, "R4 diag no pulse on idle");
            end
        end
        bit_tick = 1'b0;
    endtask

    task automatic t_plain();
        run_word(16'hA5C3, 1'b0, 1'b0, 1'b0);
        run_word(16'h8001, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_gaps();
        run_word(16'h3C96, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_line();
        run_word(16'h7E18, 1'b1, 1'b0, 1'b0);
        run_word(16'hC0F3, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_diag();
        run_word(16'hFFFF, 1'b0, 1'b1, 1'b0);
        run_word(16'h5A69, 1'b1, 1'b1, 1'b1);
        run_word(16'h0F0F, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        t_reset();
        t_prime();
        t_plain();
        t_gaps();
        t_line();
        t_diag();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule